// File: doc/BRIEF.md
# Two-Bank Cascaded Priority Interrupt Controller

This block collects sixteen level-sensitive interrupt request lines, split into a primary bank (lines 0 to 7) and a secondary bank (lines 8 to 15). Each bank keeps a pending register, a mask register and an in-service register. Each bank also chooses its own winner by fixed priority, where a lower line number always ranks higher. The secondary bank does not signal the processor directly. Its "has a candidate" output takes the place of primary input 2. All sixteen lines therefore reach the processor through one interrupt output.

The processor answers the interrupt with a one-cycle acknowledge pulse. In the next cycle the block returns an 8-bit vector and a valid strobe. The acknowledged line moves from pending to in-service. A pending line with a lower priority stays blocked until software issues an end-of-interrupt write to the bank concerned. A global enable input stands in for the processor's interrupt flag. Software reaches the two mask registers over a byte-wide I/O bus, and uses the same bus for the end-of-interrupt commands.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, int_o is 0, vec_valid_o is 0, no line is pending or in service, and both mask registers read FFh.
- R2: Writes to address 21h set the primary mask and writes to A1h set the secondary mask. io_rdata_o returns the addressed mask combinationally. Any other address reads 00h.
- R3: Mask bit n set to 1 blocks line n of that bank, with bit 0 for the lowest line. Primary mask bit 2 blocks all of lines 8 to 15.
- R4: Among the pending, unmasked primary lines, the lowest number wins. Acknowledging line n (n = 0..7, n != 2) returns vector 08h+n.
- R5: Lines 8 to 15 take part through primary input 2. Acknowledging secondary line n returns vector 70h+(n-8) and puts both primary line 2 and secondary line n in service.
- R6: irq_i[2] is ignored. Driving it alone never raises int_o.
- R7: A pending line raises no interrupt while a line of equal or higher priority in the same bank is in service.
- R8: A write of any data to 20h (primary) or A0h (secondary) clears the lowest-numbered in-service bit of that bank.
- R9: While ien_i is 0, int_o stays 0. Pending and in-service state are kept, so int_o comes back when ien_i returns to 1.
- R10: vector_o and vec_valid_o are valid in the cycle after inta_i. The acknowledged line is in service from that cycle on.
- R11: An acknowledge with no candidate returns vector 0Fh and changes no state.
- R12: A primary line raises int_o one clock edge after it is asserted. A secondary line raises int_o after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Level-sensitive request lines; bit 2 unused |
| ien_i | input | 1 | Global interrupt enable |
| io_addr_i | input | 8 | I/O address |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Mask read data for the addressed bank |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | One-cycle acknowledge pulse |
| vector_o | output | 8 | Vector returned after acknowledge |
| vec_valid_o | output | 1 | vector_o valid strobe |

## Verification
The bench targets the cascade path first.
- A secondary request must come back with a 70h-based vector and must occupy primary level 2. A design that routed the secondary bank to the wrong input, or used the wrong base, would return an 08h-range vector.

It also targets nesting and the end-of-interrupt order.
- A controller that cleared the wrong in-service bit would release a blocked lower-priority line too early, or keep a higher one blocked.

Three more corner cases are covered:
- the spurious acknowledge, where wrong handling would corrupt state or return a stray vector;
- the ignored line 2 input;
- the one-edge and two-edge request latency.

Random sequences of line levels, mask writes, acknowledges and end-of-interrupt writes are checked against a bench model after each step.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int BANK_W = 8;
  localparam int IDX_W  = $clog2(BANK_W);
  localparam int BANK_N = 2;
  typedef logic [BANK_W-1:0] bank_vec_t;
  typedef logic [IDX_W-1:0]  bank_idx_t;
  typedef struct packed {
    logic mask_wr;
    logic eoi;
  } bank_ctl_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 8,
  parameter int IW = $clog2(W),
  parameter logic [W-1:0] MASK_RST = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  req_i,
  input  logic          mask_wr_i,
  input  logic [W-1:0]  mask_wdata_i,
  input  logic          eoi_i,
  input  logic          ack_i,
  output logic [W-1:0]  mask_o,
  output logic          cand_o,
  output logic [IW-1:0] win_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]  pend_q, mask_q, svc_q;
  logic [W-1:0]  active, grant_vec, eoi_vec;
  logic          p_valid, s_valid, grant;
  logic [IW-1:0] p_idx, s_idx;

  assign active = pend_q & ~mask_q;

  irq_prio_pick #(.W(W), .IW(IW)) u_pick_pend (
    .vec_i(active), .valid_o(p_valid), .idx_o(p_idx)
  );
  irq_prio_pick #(.W(W), .IW(IW)) u_pick_svc (
    .vec_i(svc_q), .valid_o(s_valid), .idx_o(s_idx)
  );

  // candidate only if strictly above every in-service line
  assign cand_o    = p_valid & (~s_valid | (p_idx < s_idx));
  assign win_o     = p_idx;
  assign grant     = ack_i & cand_o;
  assign grant_vec = grant ? (ONE << p_idx) : '0;
  assign eoi_vec   = (eoi_i & s_valid) ? (ONE << s_idx) : '0;
  assign mask_o    = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      svc_q  <= '0;
      mask_q <= MASK_RST;
    end else begin
      pend_q <= req_i & ~grant_vec;
      svc_q  <= (svc_q & ~eoi_vec) | grant_vec;
      if (mask_wr_i) mask_q <= mask_wdata_i;
    end
  end

  a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> mask_q == $past(mask_wdata_i));

  a_r10_grant_sets_svc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> svc_q[$past(p_idx)]);

  a_r10_grant_clears_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant |=> !pend_q[$past(p_idx)]);

  a_r8_eoi_drops_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !grant && (svc_q != '0)) |=>
      ($countones(svc_q) == $countones($past(svc_q)) - 1));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          VEC_W       = 8,
  parameter logic [7:0]  M_MASK_ADDR = 8'h21,
  parameter logic [7:0]  S_MASK_ADDR = 8'hA1,
  parameter logic [7:0]  M_CMD_ADDR  = 8'h20,
  parameter logic [7:0]  S_CMD_ADDR  = 8'hA0,
  parameter logic [7:0]  M_VEC_BASE  = 8'h08,
  parameter logic [7:0]  S_VEC_BASE  = 8'h70,
  parameter int          CASC_LINE   = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*BANK_W-1:0]   irq_i,
  input  logic                  ien_i,
  input  logic [ADDR_W-1:0]     io_addr_i,
  input  logic                  io_wr_i,
  input  logic [BANK_W-1:0]     io_wdata_i,
  output logic [BANK_W-1:0]     io_rdata_o,
  output logic                  int_o,
  input  logic                  inta_i,
  output logic [VEC_W-1:0]      vector_o,
  output logic                  vec_valid_o
);
  localparam logic [ADDR_W-1:0] MASK_ADDR [BANK_N] = '{ADDR_W'(M_MASK_ADDR), ADDR_W'(S_MASK_ADDR)};
  localparam logic [ADDR_W-1:0] CMD_ADDR  [BANK_N] = '{ADDR_W'(M_CMD_ADDR),  ADDR_W'(S_CMD_ADDR)};
  localparam bank_idx_t SPUR_IDX = bank_idx_t'(BANK_W - 1);

  bank_vec_t bank_req  [BANK_N];
  bank_vec_t bank_mask [BANK_N];
  bank_ctl_t bank_ctl  [BANK_N];
  logic      bank_cand [BANK_N];
  bank_idx_t bank_win  [BANK_N];
  logic      bank_ack  [BANK_N];
  logic      unused_casc_line;

  assign unused_casc_line = irq_i[CASC_LINE];

  // primary input CASC_LINE carries the secondary bank
  always_comb begin
    bank_req[0] = irq_i[BANK_W-1:0];
    bank_req[0][CASC_LINE] = bank_cand[1];
    bank_req[1] = irq_i[2*BANK_W-1:BANK_W];
  end

  assign bank_ack[0] = inta_i;
  assign bank_ack[1] = inta_i & bank_cand[0] & (bank_win[0] == bank_idx_t'(CASC_LINE));

  for (genvar g = 0; g < BANK_N; g++) begin : g_bank
    assign bank_ctl[g].mask_wr = io_wr_i & (io_addr_i == MASK_ADDR[g]);
    assign bank_ctl[g].eoi     = io_wr_i & (io_addr_i == CMD_ADDR[g]);

    irq_bank #(.W(BANK_W), .IW(IDX_W), .MASK_RST('1)) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (bank_req[g]),
      .mask_wr_i    (bank_ctl[g].mask_wr),
      .mask_wdata_i (io_wdata_i),
      .eoi_i        (bank_ctl[g].eoi),
      .ack_i        (bank_ack[g]),
      .mask_o       (bank_mask[g]),
      .cand_o       (bank_cand[g]),
      .win_o        (bank_win[g])
    );
  end

  always_comb begin
    io_rdata_o = '0;
    for (int b = 0; b < BANK_N; b++) begin
      if (io_addr_i == MASK_ADDR[b]) io_rdata_o = bank_mask[b];
    end
  end

  assign int_o = ien_i & bank_cand[0];

  logic [VEC_W-1:0] vec_d;
  always_comb begin
    if (!bank_cand[0])
      vec_d = VEC_W'(M_VEC_BASE) + VEC_W'(SPUR_IDX);
    else if (bank_win[0] == bank_idx_t'(CASC_LINE))
      vec_d = VEC_W'(S_VEC_BASE) + VEC_W'(bank_cand[1] ? bank_win[1] : SPUR_IDX);
    else
      vec_d = VEC_W'(M_VEC_BASE) + VEC_W'(bank_win[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_o    <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= inta_i;
      if (inta_i) vector_o <= vec_d;
    end
  end

  a_r10_vec_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> vec_valid_o);

  a_r5_vec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ((vector_o[VEC_W-1:IDX_W] == M_VEC_BASE[VEC_W-1:IDX_W]) ||
                     (vector_o[VEC_W-1:IDX_W] == S_VEC_BASE[VEC_W-1:IDX_W])));

  a_r5_casc_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_ack[1] && bank_cand[1]) |=> vector_o[VEC_W-1:IDX_W] == S_VEC_BASE[VEC_W-1:IDX_W]);

  a_r11_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !bank_cand[0]) |=> vector_o == VEC_W'(M_VEC_BASE) + VEC_W'(BANK_W - 1));
endmodule

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        ien = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        int_w;
  logic        inta = 1'b0;
  logic [7:0]  vec;
  logic        vvalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_mask, s_mask, m_svc, s_svc;

  always #4 clk = ~clk;

  irq_cascade_ctrl u_irq_cascade_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ien_i(ien),
    .io_addr_i(addr), .io_wr_i(wr), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .int_o(int_w), .inta_i(inta), .vector_o(vec), .vec_valid_o(vvalid)
  );

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit s_cand();
    return lowest(irq[15:8] & ~s_mask) < lowest(s_svc);
  endfunction

  function automatic logic [7:0] m_act();
    logic [7:0] r;
    r = irq[7:0];
    r[2] = s_cand();
    return r & ~m_mask;
  endfunction

  function automatic bit m_cand();
    return lowest(m_act()) < lowest(m_svc);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_int(string req);
    chk(req, {7'b0, int_w}, {7'b0, ien & m_cand()});
  endtask

  task automatic io_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 8'h00;
    if (a == 8'h21) m_mask = d;
    if (a == 8'hA1) s_mask = d;
    if (a == 8'h20 && m_svc != 0) m_svc[lowest(m_svc)] = 1'b0;
    if (a == 8'hA0 && s_svc != 0) s_svc[lowest(s_svc)] = 1'b0;
    settle();
  endtask

  task automatic io_read(string req, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
    addr = 8'h00;
  endtask

  task automatic ack(string req);
    logic [7:0] ev;
    int mp;
    mp = lowest(m_act());
    if (!m_cand()) ev = 8'h0F;
    else if (mp == 2) begin
      m_svc[2] = 1'b1;
      if (s_cand()) begin
        ev = 8'h70 + 8'(lowest(irq[15:8] & ~s_mask));
        s_svc[lowest(irq[15:8] & ~s_mask)] = 1'b1;
      end else ev = 8'h77;
    end else begin
      ev = 8'h08 + 8'(mp);
      m_svc[mp] = 1'b1;
    end
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    chk({req, " R10 strobe"}, {7'b0, vvalid}, 8'h01);
    chk(req, vec, ev);
    settle();
  endtask

  task automatic set_irq(logic [15:0] v);
    @(negedge clk);
    irq = v;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_mask = 8'hFF; s_mask = 8'hFF; m_svc = '0; s_svc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ien = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int", {7'b0, int_w}, 8'h00);
    chk("R1 valid", {7'b0, vvalid}, 8'h00);
    io_read("R1 mask0", 8'h21, 8'hFF);
    io_read("R1 mask1", 8'hA1, 8'hFF);
    io_read("R2 other addr", 8'h20, 8'h00);
    io_write(8'h21, 8'h00);
    io_write(8'hA1, 8'h00);
    io_read("R2 mask0", 8'h21, 8'h00);
    io_read("R2 mask1", 8'hA1, 8'h00);
    io_write(8'hA1, 8'h5A);
    io_read("R2 mask1 pattern", 8'hA1, 8'h5A);
    io_write(8'hA1, 8'h00);

    // R12 latency: primary one edge, secondary two edges
    @(negedge clk);
    irq = 16'h0020;
    #1 chk("R12 before edge", {7'b0, int_w}, 8'h00);
    @(negedge clk);
    chk("R12 primary one edge", {7'b0, int_w}, 8'h01);
    set_irq(16'h0000);
    chk_int("R12 idle");
    @(negedge clk);
    irq = 16'h1000;
    @(negedge clk);
    chk("R12 secondary after one edge", {7'b0, int_w}, 8'h00);
    @(negedge clk);
    chk("R12 secondary two edges", {7'b0, int_w}, 8'h01);
    set_irq(16'h0000);

    // R6 line 2 ignored
    set_irq(16'h0004);
    chk("R6 line2 ignored", {7'b0, int_w}, 8'h00);

    // R4, R7, R8 nesting
    set_irq(16'h0042);
    ack("R4 vec 09");
    chk_int("R7 blocked by svc1");
    chk("R7 blocked", {7'b0, int_w}, 8'h00);
    set_irq(16'h0043);
    chk("R7 higher passes", {7'b0, int_w}, 8'h01);
    ack("R4 vec 08");
    set_irq(16'h0040);
    io_write(8'h20, 8'h20);
    chk("R8 eoi clears lowest only", {7'b0, int_w}, 8'h00);
    io_write(8'h20, 8'h00);
    chk("R8 second eoi releases", {7'b0, int_w}, 8'h01);
    ack("R4 vec 0E");
    io_write(8'h20, 8'h20);

    // R5 cascade
    set_irq(16'h4200);
    ack("R5 vec 71");
    chk("R5 primary level 2 in service blocks", {7'b0, int_w}, 8'h00);
    io_write(8'hA0, 8'h20);
    io_write(8'h20, 8'h20);
    chk_int("R5 after eois");
    ack("R5 vec 76");
    io_write(8'hA0, 8'h20);
    io_write(8'h20, 8'h20);

    // R3 masking
    set_irq(16'h0040);
    io_write(8'h21, 8'h40);
    chk("R3 mask bit6", {7'b0, int_w}, 8'h00);
    set_irq(16'h0800);
    io_write(8'h21, 8'h04);
    chk("R3 mask bit2 blocks secondary", {7'b0, int_w}, 8'h00);
    io_write(8'h21, 8'h00);
    io_write(8'hA1, 8'h08);
    chk("R3 secondary mask bit3", {7'b0, int_w}, 8'h00);
    io_write(8'hA1, 8'h00);

    // R9 enable gate
    set_irq(16'h0008);
    ien = 1'b0;
    settle();
    chk("R9 ien low", {7'b0, int_w}, 8'h00);
    ien = 1'b1;
    settle();
    chk("R9 ien restored", {7'b0, int_w}, 8'h01);

    // R11 spurious
    set_irq(16'h0000);
    ack("R11 spurious vec 0F");
    set_irq(16'h0080);
    chk("R11 state unchanged", {7'b0, int_w}, 8'h01);
    set_irq(16'h0000);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: set_irq(16'($urandom()));
        3: io_write(($urandom_range(0, 1) != 0) ? 8'h21 : 8'hA1,
                    8'($urandom()) & 8'($urandom()) & 8'($urandom()));
        4, 5, 6: ack("R4 R5 random ack");
        7, 8: io_write(($urandom_range(0, 1) != 0) ? 8'h20 : 8'hA0, 8'h20);
        default: begin ien = ~ien; settle(); end
      endcase
      chk_int("R7 R9 random int");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule